// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is one bank of general-purpose pins with a small register interface. Software sets each pin's direction, loads an output latch that drives the pins, and reads back two separate things. One is the pin level as seen through an input synchronizer. The other is the latch contents exactly as last written. A filtered input from an external debounce stage feeds the pin inputs.

Every pin can raise an interrupt on a falling edge, a rising edge, both edges, a high level or a low level. Three type-select registers choose the trigger. Detected events collect in a sticky status register that software clears by writing ones. A single interrupt line is raised while any pin has both its status bit and its enable bit set.

Register map, byte offsets from the block base:

| Offset | Register | Read | Write |
|---|---|---|---|
| 0x00 | value | synchronized pin level | loads the output latch |
| 0x04 | direction | direction bits | direction bits |
| 0x08 | latch readback | output latch | no effect |
| 0x10 | interrupt enable | enable bits | enable bits |
| 0x14 | sense A | trigger select | trigger select |
| 0x18 | sense B | trigger select | trigger select |
| 0x1C | sense C | trigger select | trigger select |
| 0x20 | interrupt status | sticky status | write 1 to clear |

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads 0, and `pin_out`, `pin_oe` and `irq` are 0.
- R2: Writing the direction register (0x04) sets `pin_oe` on the next clock edge. A 1 bit makes the pin an output and a 0 bit makes it an input.
- R3: Writing the value register (0x00) loads the output latch, which drives `pin_out`. The latch readback register (0x08) returns the latch contents exactly as written.
- R4: Reading the value register returns `pin_in` after a two-stage synchronizer, even for pins set as outputs. A pin change first shows in the read after the second clock edge, not after the first.
- R5: The three sense registers select each pin's trigger. With sense B = 0: sense A = 0 and sense C = 0 selects the falling edge, and sense A = 1 and sense C = 0 selects the rising edge. An edge of the other polarity sets no status.
- R6: With sense A = 1, sense B = 0 and sense C = 1, both the rising and the falling edge of the pin set its status bit.
- R7: With sense B = 1, sense A = 1 selects a high level and sense A = 0 selects a low level. The status bit is set again on every cycle the level persists, so a clear issued while the level is present has no lasting effect.
- R8: The interrupt status register (0x20) is write-one-to-clear. A 0 bit in the write data leaves that status bit unchanged.
- R9: A status bit is set only while that pin's enable bit (0x10) is 1. Events on disabled pins leave the status unchanged.
- R10: `irq` is the OR over all pins of (status AND enable). Clearing enable bits drops `irq` but keeps the pending status bits.
- R11: The interrupt registers sit at fixed offsets from the interrupt group base 0x10: enable +0x0, sense A +0x4, sense B +0x8, sense C +0xC, status +0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register at `bus_addr` |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pin_in | input | 32 | Filtered pin levels from the debounce stage |
| pin_out | output | 32 | Output latch driving the pins |
| pin_oe | output | 32 | Output enable per pin (1 = output) |
| irq | output | 1 | Combined interrupt request |

## Verification
Register writes take effect at the edge that samples the strobe. Reads are combinational, so a read placed one cycle after a write already shows the new contents. A change on `pin_in` reaches the value register two edges later and the status register three edges later, and a level trigger on a newly enabled pin fires one edge after the enable write. The bench's driver tasks wait exactly those edge counts before they queue the expected read and interrupt level. The monitor then compares each item in the same cycle, on the falling edge, while the address is held stable.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int REG_VALUE   = 'h00;
   localparam int REG_DIR     = 'h04;
   localparam int REG_LATCH   = 'h08;
   localparam int IRQ_BASE    = 'h10;
   localparam int IRQ_OFS_EN  = 'h00;
   localparam int IRQ_OFS_SA  = 'h04;
   localparam int IRQ_OFS_SB  = 'h08;
   localparam int IRQ_OFS_SC  = 'h0C;
   localparam int IRQ_OFS_ST  = 'h10;
   localparam int BUS_DW      = 32;

   typedef struct packed {
      logic sense_a;
      logic sense_b;
      logic sense_c;
   } trig_sel_t;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin : p_param_chk
      assert (STAGES >= 2) else $error("sync needs at least two stages");
   end

   logic [W-1:0] chain [STAGES];

   genvar i;
   generate
      for (i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= '0;
               else        chain[i] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= '0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_bank_detect.sv
module gpio_bank_detect
   import gpio_bank_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] en,
   input  logic [W-1:0] sense_a,
   input  logic [W-1:0] sense_b,
   input  logic [W-1:0] sense_c,
   output logic [W-1:0] hit
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   genvar p;
   generate
      for (p = 0; p < W; p++) begin : g_pin
         trig_sel_t sel;
         logic rise, fall, evt;
         assign sel  = '{sense_a: sense_a[p], sense_b: sense_b[p], sense_c: sense_c[p]};
         assign rise = lvl[p] & ~prev_q[p];
         assign fall = ~lvl[p] & prev_q[p];
         always_comb begin
            if (sel.sense_b)      evt = sel.sense_a ? lvl[p] : ~lvl[p];
            else if (sel.sense_c) evt = rise | fall;
            else                  evt = sel.sense_a ? rise : fall;
         end
         assign hit[p] = evt & en[p];
      end
   endgenerate

   // R5: an edge-mode pin whose level is unchanged raises no hit
   AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ((lvl == $past(lvl)) && (sense_b == '0)) |-> (hit == '0)); // R5
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int NPINS = 32,
   parameter int AW    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [AW-1:0]    bus_addr,
   input  logic [BUS_DW-1:0] bus_wdata,
   output logic [BUS_DW-1:0] bus_rdata,
   input  logic [NPINS-1:0] lvl,
   input  logic [NPINS-1:0] hit,
   output logic [NPINS-1:0] latch_q,
   output logic [NPINS-1:0] dir_q,
   output logic [NPINS-1:0] en_q,
   output logic [NPINS-1:0] sa_q,
   output logic [NPINS-1:0] sb_q,
   output logic [NPINS-1:0] sc_q,
   output logic [NPINS-1:0] st_q
);
   localparam logic [AW-1:0] A_VAL = AW'(REG_VALUE);
   localparam logic [AW-1:0] A_DIR = AW'(REG_DIR);
   localparam logic [AW-1:0] A_LAT = AW'(REG_LATCH);
   localparam logic [AW-1:0] A_EN  = AW'(IRQ_BASE + IRQ_OFS_EN);
   localparam logic [AW-1:0] A_SA  = AW'(IRQ_BASE + IRQ_OFS_SA);
   localparam logic [AW-1:0] A_SB  = AW'(IRQ_BASE + IRQ_OFS_SB);
   localparam logic [AW-1:0] A_SC  = AW'(IRQ_BASE + IRQ_OFS_SC);
   localparam logic [AW-1:0] A_ST  = AW'(IRQ_BASE + IRQ_OFS_ST);

   logic [NPINS-1:0] wd;
   logic             wr_val, wr_dir, wr_en, wr_sa, wr_sb, wr_sc, wr_st;
   logic [NPINS-1:0] clr;

   assign wd     = bus_wdata[NPINS-1:0];
   assign wr_val = bus_wr && (bus_addr == A_VAL);
   assign wr_dir = bus_wr && (bus_addr == A_DIR);
   assign wr_en  = bus_wr && (bus_addr == A_EN);
   assign wr_sa  = bus_wr && (bus_addr == A_SA);
   assign wr_sb  = bus_wr && (bus_addr == A_SB);
   assign wr_sc  = bus_wr && (bus_addr == A_SC);
   assign wr_st  = bus_wr && (bus_addr == A_ST);
   assign clr    = wr_st ? wd : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '0;
         en_q    <= '0;
         sa_q    <= '0;
         sb_q    <= '0;
         sc_q    <= '0;
         st_q    <= '0;
      end else begin
         if (wr_val) latch_q <= wd;
         if (wr_dir) dir_q   <= wd;
         if (wr_en)  en_q    <= wd;
         if (wr_sa)  sa_q    <= wd;
         if (wr_sb)  sb_q    <= wd;
         if (wr_sc)  sc_q    <= wd;
         st_q <= (st_q & ~clr) | hit;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_VAL:   bus_rdata[NPINS-1:0] = lvl;
         A_DIR:   bus_rdata[NPINS-1:0] = dir_q;
         A_LAT:   bus_rdata[NPINS-1:0] = latch_q;
         A_EN:    bus_rdata[NPINS-1:0] = en_q;
         A_SA:    bus_rdata[NPINS-1:0] = sa_q;
         A_SB:    bus_rdata[NPINS-1:0] = sb_q;
         A_SC:    bus_rdata[NPINS-1:0] = sc_q;
         A_ST:    bus_rdata[NPINS-1:0] = st_q;
         default: bus_rdata = '0;
      endcase
   end

   AST_STATUS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q & ~$past(st_q) & ~$past(en_q)) == '0); // R9
   AST_ZERO_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st_q) & ~st_q & ~$past(clr)) == '0); // R8
   AST_LATCH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_val |=> (latch_q == $past(wd))); // R3
   AST_DIR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> (dir_q == $past(wd))); // R2
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gpio_bank_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int AW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [AW-1:0]     bus_addr,
   input  logic [BUS_DW-1:0] bus_wdata,
   output logic [BUS_DW-1:0] bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic              irq
);
   initial begin : p_param_chk
      assert (NPINS >= 1 && NPINS <= BUS_DW) else $error("NPINS out of range");
      assert (AW >= 6) else $error("address too narrow for the map");
   end

   logic [NPINS-1:0] lvl, hit, en, sa, sb, sc, st;

   gpio_bank_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl));

   gpio_bank_detect #(.W(NPINS)) u_detect (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .en(en),
      .sense_a(sa), .sense_b(sb), .sense_c(sc), .hit(hit));

   gpio_bank_regs #(.NPINS(NPINS), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lvl(lvl), .hit(hit),
      .latch_q(pin_out), .dir_q(pin_oe), .en_q(en), .sa_q(sa), .sb_q(sb),
      .sc_q(sc), .st_q(st));

   assign irq = |(st & en);

   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> !irq); // R10
   AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == '0) |-> !irq); // R10
endmodule

// File: tb/gpio_irq_bank_bench.sv
`timescale 1ns/1ps
module gpio_irq_bank_bench;
   localparam logic [7:0] A_VAL = 8'h00, A_DIR = 8'h04, A_LAT = 8'h08;
   localparam logic [7:0] A_EN = 8'h10, A_SA = 8'h14, A_SB = 8'h18, A_SC = 8'h1C, A_ST = 8'h20;

   logic        clk = 0, rst_n = 0, bus_wr = 0, irq;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;

   int n_checks = 0, n_fail = 0;
   bit done = 0;

   typedef struct {
      logic [31:0] data;
      logic        irq_exp;
      string       tag;
   } sb_item_t;
   sb_item_t sb_q[$];

   always #5 clk = ~clk;

   gpio_irq_bank u_gpio_irq_bank (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops queued expectations mid-cycle while the address is held
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         sb_item_t it;
         it = sb_q.pop_front();
         chk({it.tag, " rdata"}, bus_rdata, it.data);
         chk({it.tag, " irq"}, {31'b0, irq}, {31'b0, it.irq_exp});
      end
   end

   task automatic expect_rd(logic [7:0] a, logic [31:0] d, logic i, string tag);
      sb_item_t it;
      @(posedge clk); #1;
      bus_addr = a;
      it.data = d; it.irq_exp = i; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(posedge clk); #1;
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 0;
   endtask

   task automatic set_pins(logic [31:0] v);
      @(posedge clk); #1;
      pin_in = v;
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin : watchdog
      #1_000_000;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin : driver
      idle(3); #1; rst_n = 1;
      // R1 reset state
      chk("R1 pin_out", pin_out, 0);
      chk("R1 pin_oe", pin_oe, 0);
      expect_rd(A_LAT, 0, 0, "R1 latch");
      expect_rd(A_DIR, 0, 0, "R1 dir");
      expect_rd(A_EN, 0, 0, "R1 enable");
      expect_rd(A_ST, 0, 0, "R1 status");
      // R2 direction
      wr(A_DIR, 32'hF0F0_0000);
      chk("R2 pin_oe", pin_oe, 32'hF0F0_0000);
      expect_rd(A_DIR, 32'hF0F0_0000, 0, "R2 dir readback");
      // R3 latch, R4 value shows pins even on outputs
      wr(A_VAL, 32'hA5A5_1234);
      chk("R3 pin_out", pin_out, 32'hA5A5_1234);
      expect_rd(A_LAT, 32'hA5A5_1234, 0, "R3 latch readback");
      expect_rd(A_VAL, 32'h0, 0, "R4 value is pin level not latch");
      // R4 synchronizer latency
      set_pins(32'h1);
      expect_rd(A_VAL, 32'h0, 0, "R4 one edge later still old");
      expect_rd(A_VAL, 32'h1, 0, "R4 two edges later new");
      idle(2);
      expect_rd(A_ST, 0, 0, "R9 no status while disabled");
      // R11 modes: pin0 fall, pin1 rise, pin2 both, pin3 high, pin4 low
      wr(A_SA, 32'h0E);
      wr(A_SB, 32'h18);
      wr(A_SC, 32'h04);
      expect_rd(A_SB, 32'h18, 0, "R11 sense B offset");
      wr(A_EN, 32'h1F);
      expect_rd(A_ST, 32'h10, 1, "R7 low level fires");
      wr(A_ST, 32'h10);
      expect_rd(A_ST, 32'h10, 1, "R7 clear under level re-sets");
      set_pins(32'h11);
      idle(2);
      expect_rd(A_ST, 32'h10, 1, "R8 sticky after level ends");
      wr(A_ST, 32'h10);
      expect_rd(A_ST, 32'h0, 0, "R8 clear after level ends");
      // R5 falling edge on pin0
      set_pins(32'h10);
      idle(2);
      expect_rd(A_ST, 32'h1, 1, "R5 falling edge");
      wr(A_ST, 32'h0);
      expect_rd(A_ST, 32'h1, 1, "R8 zero write keeps status");
      // R10 masking
      wr(A_EN, 32'h0);
      expect_rd(A_ST, 32'h1, 0, "R10 irq masked, status kept");
      // R9 disabled pin events ignored
      set_pins(32'h12);
      idle(2);
      expect_rd(A_ST, 32'h1, 0, "R9 disabled rise ignored");
      set_pins(32'h10);
      idle(2);
      wr(A_EN, 32'h1F);
      expect_rd(A_ST, 32'h1, 1, "R10 irq returns on enable");
      wr(A_ST, 32'h1);
      expect_rd(A_ST, 32'h0, 0, "R8 write one clears");
      // R5 rising edge on pin1
      set_pins(32'h12);
      idle(2);
      expect_rd(A_ST, 32'h2, 1, "R5 rising edge");
      wr(A_ST, 32'h2);
      set_pins(32'h10);
      idle(2);
      expect_rd(A_ST, 32'h0, 0, "R5 falling on rise pin ignored");
      // R6 both edges on pin2
      set_pins(32'h14);
      idle(2);
      expect_rd(A_ST, 32'h4, 1, "R6 both-edge rise");
      wr(A_ST, 32'h4);
      set_pins(32'h10);
      idle(2);
      expect_rd(A_ST, 32'h4, 1, "R6 both-edge fall");
      wr(A_ST, 32'h4);
      expect_rd(A_ST, 32'h0, 0, "R6 cleared");
      // R7 high level on pin3
      set_pins(32'h18);
      idle(2);
      expect_rd(A_ST, 32'h8, 1, "R7 high level fires");
      wr(A_ST, 32'h8);
      expect_rd(A_ST, 32'h8, 1, "R7 high level re-sets");
      set_pins(32'h10);
      idle(2);
      wr(A_ST, 32'h8);
      expect_rd(A_ST, 32'h0, 0, "R7 cleared after level drops");
      idle(2);
      finish_run();
   end
endmodule